// File: doc/BRIEF.md
# Data Object Exchange Mailbox

This block is a register-mapped mailbox that moves variable-length data objects between host software and a device-side responder. Software pushes request dwords one at a time into a write mailbox register, then sets a GO bit in the control register. The block checks the first request dword against a parameterised table of supported protocol headers. It also checks that the declared length in the second dword equals the number of dwords actually written. Only a request that passes both checks is handed to the responder. A request that fails either check is dropped without any trace in the status register.

The responder reads the stored request through an indexed port and pushes its answer dword by dword. It then signals completion, optionally flagging a failure. Software drains the answer through the read mailbox register. It reads the current dword and then writes the same register to step to the next one; the step past the last dword empties the mailbox. An abort bit in the control register returns everything to the empty state. A one-cycle interrupt request marks each completion when interrupts are both supported and enabled.

The control flow is a three-state machine. IDLE collects request dwords. BUSY waits for the responder. READY holds a response for draining. The transitions are:
- GO_ACCEPT (IDLE to BUSY) on an accepted GO.
- RESP_DONE (BUSY to READY) on a successful completion.
- RESP_FAIL (BUSY to IDLE) on a flagged or empty completion.
- DRAIN_END (READY to IDLE) on the final read-mailbox step.
- ABORT (any state to IDLE).

Top module: `doe_mailbox`

## Requirements
- R1: The capabilities register at byte offset 0x04 reads the interrupt-supported flag in bit 0 and the 11-bit interrupt message number in bits 11:1, with all other bits 0. Reads of any offset other than 0x04, 0x08, 0x0C, 0x10 and 0x14 return 0, and the write mailbox at 0x10 also reads 0.
- R2: In the control register at 0x08, bit 1 is interrupt enable and reads back as written. Bit 0 (abort) and bit 31 (GO) always read 0.
- R3: The status register at 0x0C reports busy in bit 0, interrupt status in bit 1, error in bit 2 and response ready in bit 31. Writing 1 to bit 1 clears interrupt status.
- R4: On GO in IDLE, a request is accepted and busy rises on the next cycle only if both of these hold. First, dword 0 equals one table entry, each entry being {8'h00, type[7:0] in bits 23:16, vendor[15:0] in bits 15:0}. Second, dword 1 bits 17:0 equal the count of dwords written, and that count is at least 2. While busy, the responder port presents the matching table index (lowest index on duplicates) and the request length.
- R5: A GO whose header or length check fails discards the request. Busy, ready and error all stay 0, and the write count returns to 0, so that a following valid request is accepted.
- R6: A control write with bit 0 set aborts. It clears ready, error and busy, empties both mailboxes and resets the read index. It takes priority over GO in the same write.
- R7: Reading the read mailbox at 0x14 returns 0 while ready is clear, and the response dword at the current read index while ready is set.
- R8: Each write to 0x14 while ready advances the read index. The write that reaches the response length clears ready and empties both mailboxes.
- R9: A completion, whether to READY or with error, produces a one-cycle irq pulse and sets interrupt status only when interrupt support and interrupt enable are both 1.
- R10: Write-mailbox writes beyond DEPTH dwords are dropped. A request declaring DEPTH+1 dwords is therefore discarded on GO, while exactly DEPTH dwords is accepted.
- R11: Write-mailbox writes while busy are ignored and do not change the request length seen by the responder.
- R12: A completion flagged as failed, or one carrying zero response dwords, sets error, leaves ready clear, and returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Dword-aligned byte offset within the block |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| irq | output | 1 | One-cycle interrupt request pulse |
| rsp_req | output | 1 | Request accepted and awaiting the responder (busy) |
| rsp_proto | output | PIDX_W | Index of the matched protocol table entry |
| req_len | output | CNT_W | Request length in dwords |
| req_idx | input | AW | Request dword index to read |
| req_data | output | 32 | Request dword at req_idx |
| rsp_push | input | 1 | Responder pushes one response dword |
| rsp_data | input | 32 | Response dword |
| rsp_done | input | 1 | Responder completion strobe |
| rsp_err | input | 1 | Completion is a failure (with rsp_done) |

## Verification
The bench builds the block with DEPTH set to 8, two protocol entries and interrupt support on, using a distinctive message number. The small depth makes the overflow boundary reachable in a few writes: DEPTH and DEPTH+1 dword requests are both exercised directly, and random requests span the full legal length range. With two protocol entries, both the successful path and the responder-failure path can be driven by header choice alone. Random iterations mix valid, failing, wrong-header and wrong-length requests with random interrupt enable.

// File: rtl/doe_pkg.sv
package doe_pkg;
    localparam int unsigned REG_AW = 8;
    localparam int unsigned LEN_W  = 18;

    localparam logic [REG_AW-1:0] OFF_CAP  = 8'h04;
    localparam logic [REG_AW-1:0] OFF_CTRL = 8'h08;
    localparam logic [REG_AW-1:0] OFF_STAT = 8'h0C;
    localparam logic [REG_AW-1:0] OFF_WRMB = 8'h10;
    localparam logic [REG_AW-1:0] OFF_RDMB = 8'h14;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_READY = 2'd2
    } mb_state_t;
endpackage

// File: rtl/doe_dw_buf.sv
module doe_dw_buf #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    logic [31:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/doe_hdr_check.sv
module doe_hdr_check
    import doe_pkg::*;
#(
    parameter int unsigned NUM_PROTO = 2,
    parameter int unsigned PIDX_W    = 1,
    parameter int unsigned CNT_W     = 7,
    parameter logic [NUM_PROTO-1:0][31:0] PROTO_HDRS = '0
) (
    input  logic [31:0]       hdr0,
    input  logic [31:0]       hdr1,
    input  logic [CNT_W-1:0]  count,
    output logic              accept,
    output logic [PIDX_W-1:0] idx
);
    logic [NUM_PROTO-1:0] hit;
    logic                 len_ok;

    for (genvar g = 0; g < NUM_PROTO; g++) begin : g_cmp
        assign hit[g] = (hdr0 == PROTO_HDRS[g]);
    end

    // Lowest matching index wins
    always_comb begin
        idx = '0;
        for (int i = NUM_PROTO - 1; i >= 0; i--) begin
            if (hit[i]) idx = PIDX_W'(i);
        end
    end

    assign len_ok = (count >= CNT_W'(2)) && (hdr1[LEN_W-1:0] == LEN_W'(count));
    assign accept = (|hit) && len_ok;
endmodule

// File: rtl/doe_mailbox.sv
module doe_mailbox
    import doe_pkg::*;
#(
    parameter int unsigned DEPTH       = 64,
    parameter int unsigned NUM_PROTO   = 2,
    parameter logic [NUM_PROTO-1:0][31:0] PROTO_HDRS = {32'h0001_0001, 32'h0000_0001},
    parameter logic        IRQ_SUPPORT = 1'b1,
    parameter logic [10:0] IRQ_MSG_NUM = 11'd3,
    localparam int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
    localparam int unsigned PIDX_W = (NUM_PROTO > 1) ? $clog2(NUM_PROTO) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              rsp_req,
    output logic [PIDX_W-1:0] rsp_proto,
    output logic [CNT_W-1:0]  req_len,
    input  logic [AW-1:0]     req_idx,
    output logic [31:0]       req_data,
    input  logic              rsp_push,
    input  logic [31:0]       rsp_data,
    input  logic              rsp_done,
    input  logic              rsp_err
);
    mb_state_t state_q, state_d;

    logic [CNT_W-1:0]  wr_len, rsp_cnt, rd_idx;
    logic [31:0]       hdr0_q, hdr1_q, rd_dw;
    logic [PIDX_W-1:0] proto_q, proto_hit;
    logic              err_q, int_en_q, int_sts_q, irq_q, hdr_ok;

    // Access decode
    logic wr_ctrl, do_abort, do_go, go_ok, go_bad;
    logic wmb_wr, rsp_wr, resp_end, resp_fail, rdm_step, drain_end, done_evt;

    assign wr_ctrl   = reg_wr && (reg_addr == OFF_CTRL);
    assign do_abort  = wr_ctrl && reg_wdata[0];
    assign do_go     = wr_ctrl && !reg_wdata[0] && reg_wdata[31] && (state_q == ST_IDLE);
    assign go_ok     = do_go && hdr_ok;
    assign go_bad    = do_go && !hdr_ok;
    assign wmb_wr    = reg_wr && (reg_addr == OFF_WRMB) && (state_q == ST_IDLE)
                       && (wr_len < CNT_W'(DEPTH));
    assign rsp_wr    = (state_q == ST_BUSY) && rsp_push && !do_abort
                       && (rsp_cnt < CNT_W'(DEPTH));
    assign resp_end  = (state_q == ST_BUSY) && rsp_done && !do_abort;
    assign resp_fail = resp_end && (rsp_err || (rsp_cnt == '0));
    assign rdm_step  = reg_wr && (reg_addr == OFF_RDMB) && (state_q == ST_READY) && !do_abort;
    assign drain_end = rdm_step && ((rd_idx + CNT_W'(1)) == rsp_cnt);
    assign done_evt  = resp_end && IRQ_SUPPORT && int_en_q;

    doe_hdr_check #(
        .NUM_PROTO (NUM_PROTO),
        .PIDX_W    (PIDX_W),
        .CNT_W     (CNT_W),
        .PROTO_HDRS(PROTO_HDRS)
    ) i_hdr (
        .hdr0  (hdr0_q),
        .hdr1  (hdr1_q),
        .count (wr_len),
        .accept(hdr_ok),
        .idx   (proto_hit)
    );

    doe_dw_buf #(.DEPTH(DEPTH), .AW(AW)) i_wbuf (
        .clk  (clk),
        .we   (wmb_wr),
        .waddr(wr_len[AW-1:0]),
        .wdata(reg_wdata),
        .raddr(req_idx),
        .rdata(req_data)
    );

    doe_dw_buf #(.DEPTH(DEPTH), .AW(AW)) i_rbuf (
        .clk  (clk),
        .we   (rsp_wr),
        .waddr(rsp_cnt[AW-1:0]),
        .wdata(rsp_data),
        .raddr(rd_idx[AW-1:0]),
        .rdata(rd_dw)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go_ok)     state_d = ST_BUSY;   // GO_ACCEPT
            ST_BUSY:  if (resp_fail) state_d = ST_IDLE;   // RESP_FAIL
                      else if (resp_end) state_d = ST_READY; // RESP_DONE
            ST_READY: if (drain_end) state_d = ST_IDLE;   // DRAIN_END
            default:  state_d = ST_IDLE;
        endcase
        if (do_abort) state_d = ST_IDLE;                  // ABORT
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_len    <= '0;
            rsp_cnt   <= '0;
            rd_idx    <= '0;
            hdr0_q    <= '0;
            hdr1_q    <= '0;
            proto_q   <= '0;
            err_q     <= 1'b0;
            int_en_q  <= 1'b0;
            int_sts_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            irq_q <= done_evt;
            if (wr_ctrl) int_en_q <= reg_wdata[1];
            if (done_evt) int_sts_q <= 1'b1;
            else if (reg_wr && (reg_addr == OFF_STAT) && reg_wdata[1]) int_sts_q <= 1'b0;

            if (do_abort || go_bad || drain_end || resp_fail) begin
                wr_len  <= '0;
                rsp_cnt <= '0;
                rd_idx  <= '0;
                hdr0_q  <= '0;
                hdr1_q  <= '0;
            end else begin
                if (wmb_wr) begin
                    wr_len <= wr_len + CNT_W'(1);
                    if (wr_len == CNT_W'(0)) hdr0_q <= reg_wdata;
                    if (wr_len == CNT_W'(1)) hdr1_q <= reg_wdata;
                end
                if (go_ok) begin
                    rsp_cnt <= '0;
                    rd_idx  <= '0;
                    proto_q <= proto_hit;
                end
                if (rsp_wr)   rsp_cnt <= rsp_cnt + CNT_W'(1);
                if (rdm_step) rd_idx  <= rd_idx + CNT_W'(1);
            end

            if (do_abort)       err_q <= 1'b0;
            else if (resp_fail) err_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFF_CAP:  reg_rdata = {20'b0, IRQ_MSG_NUM, IRQ_SUPPORT};
            OFF_CTRL: reg_rdata = {30'b0, int_en_q, 1'b0};
            OFF_STAT: reg_rdata = {(state_q == ST_READY), 28'b0, err_q, int_sts_q,
                                   (state_q == ST_BUSY)};
            OFF_RDMB: reg_rdata = (state_q == ST_READY) ? rd_dw : 32'b0;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq       = irq_q;
    assign rsp_req   = (state_q == ST_BUSY);
    assign rsp_proto = proto_q;
    assign req_len   = wr_len;
endmodule

// File: rtl/doe_mailbox_chk.sv
module doe_mailbox_chk
    import doe_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [7:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [31:0]      reg_rdata,
    input logic             irq,
    input logic             rsp_req,
    input mb_state_t        state_q,
    input logic             err_q,
    input logic [CNT_W-1:0] wr_len
);
    p_ctrl_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFF_CTRL) |-> (reg_rdata[0] == 1'b0 && reg_rdata[31] == 1'b0));

    p_abort_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_CTRL && reg_wdata[0])
        |=> (state_q == ST_IDLE && !err_q && wr_len == '0));

    p_rdmb_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_READY && reg_addr == OFF_RDMB) |-> (reg_rdata == 32'b0));

    p_irq_on_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(rsp_req) && !rsp_req));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_len <= CNT_W'(DEPTH));

    p_busy_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_req && $past(rsp_req)) |-> $stable(wr_len));
endmodule

bind doe_mailbox doe_mailbox_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .irq      (irq),
    .rsp_req  (rsp_req),
    .state_q  (state_q),
    .err_q    (err_q),
    .wr_len   (wr_len)
);

// File: tb/test_doe_mailbox.sv
module test_doe_mailbox;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned DEPTH      = 8;
    localparam int unsigned AW         = 3;
    localparam int unsigned CNT_W      = 4;
    localparam logic [10:0] MSG        = 11'h2A5;
    localparam logic [31:0] HDR_OK     = 32'h0000_0001;
    localparam logic [31:0] HDR_FAIL   = 32'h0001_0001;
    localparam logic [7:0]  A_CAP = 8'h04, A_CTRL = 8'h08, A_STAT = 8'h0C,
                            A_WRMB = 8'h10, A_RDMB = 8'h14;

    logic clk = 0, rst_n = 0;
    logic reg_wr = 0;
    logic [7:0] reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata, req_data;
    logic [31:0] rsp_data = 0;
    logic irq, rsp_req, rsp_push = 0, rsp_done = 0, rsp_err = 0;
    logic [0:0] rsp_proto;
    logic [CNT_W-1:0] req_len;
    logic [AW-1:0] req_idx = 0;
    logic resp_hold = 0;

    int n_chk = 0, n_fail = 0, irq_cnt = 0;
    logic [31:0] req_q [16];
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    doe_mailbox #(
        .DEPTH(DEPTH), .NUM_PROTO(2),
        .PROTO_HDRS({HDR_FAIL, HDR_OK}),
        .IRQ_SUPPORT(1'b1), .IRQ_MSG_NUM(MSG)
    ) i_doe_mailbox (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .rsp_req(rsp_req), .rsp_proto(rsp_proto), .req_len(req_len),
        .req_idx(req_idx), .req_data(req_data), .rsp_push(rsp_push),
        .rsp_data(rsp_data), .rsp_done(rsp_done), .rsp_err(rsp_err)
    );

    always @(negedge clk) if (irq) irq_cnt++;

    // Responder: answers with inverted request dwords; entry 1 fails
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_req && !resp_hold) begin
                for (int i = 0; i < int'(req_len); i++) begin
                    req_idx = AW'(i);
                    #1;
                    rsp_data = ~req_data;
                    rsp_push = 1;
                    @(negedge clk);
                end
                rsp_push = 0;
                rsp_done = 1;
                rsp_err  = (rsp_proto == 1'b1);
                @(negedge clk);
                rsp_done = 0;
                rsp_err  = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rreg(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_wr = 0; reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] exp_stat(input logic rdy, input logic err,
                                             input logic ists, input logic bsy);
        return {rdy, 28'b0, err, ists, bsy};
    endfunction

    task automatic load_req(input int n, input logic [31:0] h0, input int decl);
        req_q[0] = h0;
        req_q[1] = 32'(decl);
        for (int i = 2; i < 16; i++) req_q[i] = $urandom;
        for (int i = 0; i < n; i++) wreg(A_WRMB, req_q[i]);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 100; k++) begin
            rreg(A_STAT, rv);
            if (!rv[0]) break;
        end
    endtask

    // Drain n dwords, checking data and the ready bit along the way
    task automatic drain(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            rreg(A_RDMB, rv);
            chk({tag, " data"}, rv, ~req_q[i]);
            rreg(A_STAT, rv);
            chk({tag, " ready held"}, 32'(rv[31]), 32'd1);
            wreg(A_RDMB, 32'h0);
        end
        rreg(A_STAT, rv);
        chk({tag, " R8 ready cleared"}, 32'(rv[31]), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) req_q[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // Reset state and fixed registers
        rreg(A_STAT, rv); chk("R3 reset status", rv, 32'h0);
        rreg(A_CAP, rv);  chk("R1 cap reg", rv, {20'b0, MSG, 1'b1});
        rreg(8'h00, rv);  chk("R1 unimpl 0x00", rv, 32'h0);
        rreg(8'h18, rv);  chk("R1 unimpl 0x18", rv, 32'h0);
        rreg(A_WRMB, rv); chk("R1 wrmb reads 0", rv, 32'h0);
        rreg(A_RDMB, rv); chk("R7 rdmb idle 0", rv, 32'h0);
        wreg(A_CTRL, 32'h0000_0002);
        rreg(A_CTRL, rv); chk("R2 int enable readback", rv, 32'h2);

        // Valid request held busy; extra write while busy is ignored
        resp_hold = 1;
        load_req(4, HDR_OK, 4);
        wreg(A_CTRL, 32'h8000_0002);
        rreg(A_STAT, rv); chk("R4 busy after go", rv, exp_stat(0, 0, 0, 1));
        chk("R4 proto idx", 32'(rsp_proto), 32'd0);
        chk("R4 req len", 32'(req_len), 32'd4);
        rreg(A_CTRL, rv); chk("R2 go reads 0", rv, 32'h2);
        wreg(A_WRMB, 32'hDEAD_BEEF);
        chk("R11 len unchanged while busy", 32'(req_len), 32'd4);
        resp_hold = 0;
        wait_idle();
        rreg(A_STAT, rv); chk("R3 ready+int status", rv, exp_stat(1, 0, 1, 0));
        chk("R9 irq pulse", 32'(irq_cnt), 32'd1);
        drain(4, "R7 R11 first");
        wreg(A_STAT, 32'h2);
        rreg(A_STAT, rv); chk("R3 int status w1c", rv, 32'h0);

        // Discards: wrong header, wrong length
        load_req(3, 32'h0000_0002, 3);
        wreg(A_CTRL, 32'h8000_0002);
        rreg(A_STAT, rv); chk("R5 bad header discard", rv, 32'h0);
        load_req(4, HDR_OK, 5);
        wreg(A_CTRL, 32'h8000_0002);
        rreg(A_STAT, rv); chk("R5 bad length discard", rv, 32'h0);
        load_req(1, HDR_OK, 1);
        wreg(A_CTRL, 32'h8000_0002);
        rreg(A_STAT, rv); chk("R4 single dword rejected", rv, 32'h0);
        load_req(3, HDR_OK, 3);
        wreg(A_CTRL, 32'h8000_0002);
        wait_idle();
        rreg(A_STAT, rv); chk("R5 count reset after discard", 32'(rv[31]), 32'd1);
        drain(3, "R5 follow-up");

        // Responder failure -> error, then abort clears
        wreg(A_STAT, 32'h2);
        irq_cnt = 0;
        load_req(2, HDR_FAIL, 2);
        wreg(A_CTRL, 32'h8000_0002);
        wait_idle();
        rreg(A_STAT, rv); chk("R12 error set", rv, exp_stat(0, 1, 1, 0));
        chk("R9 irq on error", 32'(irq_cnt), 32'd1);
        rreg(A_RDMB, rv); chk("R7 rdmb 0 on error", rv, 32'h0);
        wreg(A_CTRL, 32'h0000_0003);
        rreg(A_STAT, rv); chk("R6 abort clears error", rv, exp_stat(0, 0, 1, 0));

        // Abort beats GO in the same write, and empties the write mailbox
        load_req(3, HDR_OK, 3);
        wreg(A_CTRL, 32'h8000_0003);
        rreg(A_STAT, rv); chk("R6 abort over go", 32'(rv[0] | rv[31]), 32'd0);
        load_req(2, HDR_OK, 2);
        wreg(A_CTRL, 32'h8000_0002);
        wait_idle();
        rreg(A_STAT, rv); chk("R6 mailbox emptied", 32'(rv[31]), 32'd1);
        // Abort mid-drain
        rreg(A_RDMB, rv); chk("R7 first dword", rv, ~req_q[0]);
        wreg(A_RDMB, 32'h0);
        wreg(A_CTRL, 32'h0000_0003);
        rreg(A_STAT, rv); chk("R6 abort clears ready", 32'(rv[31]), 32'd0);
        rreg(A_RDMB, rv); chk("R6 R7 rdmb 0 after abort", rv, 32'h0);

        // Depth boundary
        load_req(DEPTH + 1, HDR_OK, DEPTH + 1);
        wreg(A_CTRL, 32'h8000_0002);
        rreg(A_STAT, rv); chk("R10 overflow discarded", 32'(rv[0] | rv[31]), 32'd0);
        load_req(DEPTH, HDR_OK, DEPTH);
        wreg(A_CTRL, 32'h8000_0002);
        wait_idle();
        rreg(A_STAT, rv); chk("R10 full depth accepted", 32'(rv[31]), 32'd1);
        drain(DEPTH, "R10 full");

        // Interrupt disabled -> no pulse
        wreg(A_STAT, 32'h2);
        irq_cnt = 0;
        load_req(2, HDR_OK, 2);
        wreg(A_CTRL, 32'h8000_0000);
        wait_idle();
        rreg(A_STAT, rv); chk("R9 no int status when disabled", rv, exp_stat(1, 0, 0, 0));
        chk("R9 no irq when disabled", 32'(irq_cnt), 32'd0);
        drain(2, "R9 disabled");

        // Random mix
        for (int it = 0; it < 40; it++) begin
            int kind, n;
            logic en;
            kind = $urandom_range(0, 3);
            n    = $urandom_range(2, DEPTH);
            en   = 1'($urandom_range(0, 1));
            wreg(A_STAT, 32'h2);
            irq_cnt = 0;
            case (kind)
                0: load_req(n, HDR_OK, n);
                1: load_req(n, HDR_FAIL, n);
                2: load_req(n, 32'h0003_0001, n);
                default: load_req(n, HDR_OK, n + 1);
            endcase
            wreg(A_CTRL, {1'b1, 29'b0, en, 1'b0});
            wait_idle();
            rreg(A_STAT, rv);
            case (kind)
                0: begin
                    chk("R4 R9 rand ready", rv, exp_stat(1, 0, en, 0));
                    drain(n, "R8 rand");
                end
                1: begin
                    chk("R12 rand error", rv, exp_stat(0, 1, en, 0));
                    wreg(A_CTRL, 32'h1);
                end
                default: chk("R5 rand discard", rv, 32'h0);
            endcase
            chk("R9 rand irq count", 32'(irq_cnt), (kind < 2 && en) ? 32'd1 : 32'd0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule